// File: doc/BRIEF.md
# Scatter-Gather DMA Descriptor Dispatcher

This block is the front end that a host uses to feed a scatter-gather DMA engine. The host builds a descriptor one 32-bit word at a time in a staging window of eight words. The descriptor is queued in a descriptor FIFO only when the host writes the last word, the control word, with its go bit set. A sequencer takes descriptors from the head of the FIFO, offers each one to a downstream data mover over a valid/ready handshake, and then waits for a completion pulse. That pulse carries an eight-bit error vector and an early-termination flag.

A second window of 32-bit registers lets the host see status and control the block. The host can halt dispatch, run a timed soft reset, read fill levels and sequence numbers, clear sticky flags by writing ones, and enable the interrupt line. The sequencer has four named states. ST_IDLE moves to ST_ISSUE when the FIFO holds a descriptor and no halt condition is present. ST_ISSUE moves to ST_WAIT when the mover accepts the descriptor. ST_WAIT moves back to ST_IDLE on the completion pulse. Any state moves to ST_RESET when a soft reset is requested. ST_RESET moves to ST_IDLE when its cycle counter runs out.

Top module: `sgdma_dispatcher`

## Requirements
- R1: Descriptor-window writes to word indices 0 through 6 only update the staging registers. A write to index 7 (the control word) with bit 31 clear pushes nothing. A write to index 7 with bit 31 set pushes all eight staged words into the FIFO, with the new control word included. On `cmd_desc`, word i sits at bits 32i+31:32i. The sequence number is word 3, bits 15:0.
- R2: Descriptors leave in the order they were committed. A commit made while the FIFO holds FIFO_DEPTH entries is dropped, and the entries already queued are not changed.
- R3: `cmd_valid` and `cmd_desc` stay steady until `cmd_ready` is seen. Only one descriptor is in flight at a time: no new offer is made until a completion pulse has arrived. A completion pulse is ignored when no descriptor is in flight.
- R4: The status word (CSR index 0) reads as follows. Bit 0 is busy: a descriptor is in flight or the FIFO is non-empty. Bit 1 is FIFO empty. Bit 2 is FIFO full. Bit 3 reads 1 and bit 4 reads 0. Bit 5 is stopped: a halt condition is present and nothing is in flight. Bit 6 is resetting. After reset the status word reads 0x00A.
- R5: Status bits 9 (interrupt pending), 8 (stopped on early termination) and 7 (stopped on error) are sticky. Writing 1 to one of them clears it, and writing 0 leaves it unchanged. If a set and a clear happen in the same cycle, the set wins.
- R6: A completion sets interrupt pending in any of three cases: the in-flight control word has bit 14 set; the error vector ANDed with control bits 23:16 is non-zero; or the early flag is set together with control bit 15. `irq` equals interrupt pending ANDed with control-register bit 4.
- R7: With control-register bit 2 set, a completion with a non-zero error vector sets status bit 7. While status bit 7 is set, no descriptor is popped. Clearing it resumes dispatch.
- R8: With control-register bit 3 set, a completion with the early flag sets status bit 8, and dispatch halts until that bit is cleared.
- R9: Control-register bit 0 (stop) and bit 5 (stop fetching) each keep a waiting descriptor from being offered while they are set.
- R10: Writing 1 to control-register bit 1 starts a soft reset. The FIFO empties and the staging words clear on that same write edge. Status bit 6 and the read-back of control bit 1 then stay high for exactly RST_CYCLES cycles (16 by default) and drop by themselves.
- R11: CSR index 2 reads the FIFO fill level in both bits 31:16 and bits 15:0. CSR index 4 reads, in bits 15:0, the sequence number of the last descriptor popped, and in bits 31:16, the sequence number of the last descriptor completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_wr_en | input | 1 | Descriptor-window write strobe |
| desc_wr_idx | input | 3 | Descriptor word index |
| desc_wr_data | input | 32 | Descriptor write data |
| csr_wr_en | input | 1 | Register-window write strobe |
| csr_idx | input | 3 | Register word index (byte offset / 4) for reads and writes |
| csr_wr_data | input | 32 | Register write data |
| csr_rd_data | output | 32 | Register read data, combinational from `csr_idx` |
| cmd_valid | output | 1 | Descriptor offered to the data mover |
| cmd_ready | input | 1 | Data mover accepts the descriptor |
| cmd_desc | output | 256 | Offered descriptor, eight packed words |
| done_pulse | input | 1 | One-cycle completion of the in-flight descriptor |
| done_err | input | 8 | Error vector of the completion |
| done_early | input | 1 | Early-termination flag of the completion |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle: that an offered descriptor stays steady until it is accepted; that a halt seen in idle keeps the offer low; that a completion does not lead straight to a new offer; that a reset request leaves the FIFO empty; that a commit into a full FIFO leaves its count unchanged; and that an interrupt cause always sets the pending flag. Some behaviours need the bench's scenarios. These are the exact descriptor contents and their order through the FIFO, the dropped commit on a full FIFO, the write-one-to-clear semantics, the 16-cycle reset window, and the sequence-number read-back. They can only be shown by comparing the ports against a reference queue and register model.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 8;
    localparam int IDX_W     = $clog2(NUM_WORDS);
    localparam int DESC_W    = WORD_W * NUM_WORDS;
    localparam int CTRL_IDX  = 7;
    localparam int SEQ_IDX   = 3;
    localparam int GO_BIT    = 31;

    // descriptor control word fields used by the sequencer
    localparam int DC_CMPL_IRQ  = 14;
    localparam int DC_EARLY_IRQ = 15;
    localparam int DC_MASK_LO   = 16;

    // control register bits
    localparam int KB_STOP       = 0;
    localparam int KB_RESET      = 1;
    localparam int KB_STOP_ERR   = 2;
    localparam int KB_STOP_EARLY = 3;
    localparam int KB_GIE        = 4;
    localparam int KB_STOP_FETCH = 5;

    // status register bits
    localparam int SB_STOP_ERR   = 7;
    localparam int SB_STOP_EARLY = 8;
    localparam int SB_IRQ        = 9;

    typedef logic [DESC_W-1:0] desc_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_RESET
    } seq_state_t;
endpackage

// File: rtl/sgd_stage.sv
module sgd_stage
    import sgd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    output desc_t             staged,
    output logic              commit
);
    logic [WORD_W-1:0] words_q [NUM_WORDS];

    assign commit = wr_en && !flush && (wr_idx == IDX_W'(CTRL_IDX)) && wr_data[GO_BIT];

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words_q[i] <= '0;
            end else if (flush) begin
                words_q[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                words_q[i] <= wr_data;
            end
        end

        if (i == CTRL_IDX) begin : g_ctl
            // the committing control word is forwarded in the same cycle
            assign staged[i*WORD_W +: WORD_W] = commit ? wr_data : words_q[i];
        end else begin : g_dat
            assign staged[i*WORD_W +: WORD_W] = words_q[i];
        end
    end
endmodule

// File: rtl/sgd_fifo.sv
module sgd_fifo #(
    parameter int WIDTH = 256,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       push,
    input  logic                       pop,
    input  logic [WIDTH-1:0]           din,
    output logic [WIDTH-1:0]           dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !clear;
    assign do_pop  = pop && !empty && !clear;
    assign dout    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2: a commit into a full FIFO leaves its occupancy alone
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop && !clear |=> count == $past(count));

    p_pop_has_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/sgd_seq.sv
module sgd_seq
    import sgd_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reset_req,
    input  logic        halt,
    input  logic        head_avail,
    input  logic [9:0]  head_irq_bits,
    input  logic [15:0] head_seq,
    input  logic        cmd_ready,
    input  logic        done_pulse,
    input  logic [7:0]  done_err,
    input  logic        done_early,
    output logic        cmd_valid,
    output logic        pop,
    output logic        in_reset,
    output logic        active,
    output logic        set_ip,
    output logic        err_hit,
    output logic        early_hit,
    output logic [15:0] rd_seq,
    output logic [15:0] wr_seq
);
    localparam int RC_W = $clog2(RST_CYCLES + 1);
    // offsets inside head_irq_bits (control bits 23:14)
    localparam int OFF_CMPL  = DC_CMPL_IRQ - DC_CMPL_IRQ;
    localparam int OFF_EARLY = DC_EARLY_IRQ - DC_CMPL_IRQ;
    localparam int OFF_MASK  = DC_MASK_LO - DC_CMPL_IRQ;

    seq_state_t       state_q, state_d;
    logic [RC_W-1:0]  rcnt_q;
    logic [9:0]       fl_bits_q;
    logic             done_seen;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (reset_req) begin
            state_d = ST_RESET;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (head_avail && !halt) state_d = ST_ISSUE;
                ST_ISSUE: if (cmd_ready)           state_d = ST_WAIT;
                ST_WAIT:  if (done_pulse)          state_d = ST_IDLE;
                ST_RESET: if (rcnt_q == '0)        state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        cmd_valid = (state_q == ST_ISSUE);
        pop       = cmd_valid && cmd_ready && !reset_req;
        in_reset  = (state_q == ST_RESET);
        active    = (state_q == ST_ISSUE) || (state_q == ST_WAIT);
        done_seen = (state_q == ST_WAIT) && done_pulse && !reset_req;
        set_ip    = done_seen && (fl_bits_q[OFF_CMPL]
                                  || (|(done_err & fl_bits_q[OFF_MASK +: 8]))
                                  || (done_early && fl_bits_q[OFF_EARLY]));
        err_hit   = done_seen && (|done_err);
        early_hit = done_seen && done_early;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcnt_q    <= '0;
            fl_bits_q <= '0;
            rd_seq    <= '0;
            wr_seq    <= '0;
        end else begin
            if (reset_req) begin
                rcnt_q <= RC_W'(RST_CYCLES - 1);
            end else if (in_reset && rcnt_q != '0) begin
                rcnt_q <= rcnt_q - 1'b1;
            end
            if (pop) begin
                fl_bits_q <= head_irq_bits;
                rd_seq    <= head_seq;
            end
            if (done_seen) begin
                wr_seq <= rd_seq;
            end
        end
    end

    // R3: a completion returns to idle, never straight to a new offer
    p_one_in_flight_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |=> !cmd_valid);

    // R10: the reset window does not end while the counter still runs
    p_reset_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_reset && rcnt_q != '0 |=> in_reset);
endmodule

// File: rtl/sgdma_dispatcher.sv
module sgdma_dispatcher
    import sgd_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int RST_CYCLES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 desc_wr_en,
    input  logic [IDX_W-1:0]     desc_wr_idx,
    input  logic [WORD_W-1:0]    desc_wr_data,
    input  logic                 csr_wr_en,
    input  logic [2:0]           csr_idx,
    input  logic [WORD_W-1:0]    csr_wr_data,
    output logic [WORD_W-1:0]    csr_rd_data,
    output logic                 cmd_valid,
    input  logic                 cmd_ready,
    output logic [DESC_W-1:0]    cmd_desc,
    input  logic                 done_pulse,
    input  logic [7:0]           done_err,
    input  logic                 done_early,
    output logic                 irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    desc_t             staged;
    logic              commit, flush, reset_req;
    logic              fifo_clear, fifo_pop, fifo_full, fifo_empty;
    logic [CNT_W-1:0]  fifo_count;
    desc_t             head;
    logic              in_reset, active, set_ip, err_hit, early_hit;
    logic [15:0]       rd_seq, wr_seq;
    logic [5:0]        ctrl_q;
    logic              ip_q, serr_q, searly_q;
    logic              halt, stat_wr, ctrl_wr;
    logic [15:0]       fill16;
    logic [WORD_W-1:0] status_w, control_w;
    logic              csr_unused;

    assign stat_wr   = csr_wr_en && (csr_idx == 3'd0);
    assign ctrl_wr   = csr_wr_en && (csr_idx == 3'd1);
    assign reset_req = ctrl_wr && csr_wr_data[KB_RESET] && !in_reset;
    assign flush     = reset_req || in_reset;
    assign fifo_clear = flush;
    assign halt      = ctrl_q[KB_STOP] || ctrl_q[KB_STOP_FETCH] || serr_q || searly_q;
    assign csr_unused = ^csr_wr_data[WORD_W-1:10] ^ csr_wr_data[6];

    sgd_stage u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_en   (desc_wr_en),
        .wr_idx  (desc_wr_idx),
        .wr_data (desc_wr_data),
        .staged  (staged),
        .commit  (commit)
    );

    sgd_fifo #(
        .WIDTH (DESC_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (fifo_clear),
        .push  (commit),
        .pop   (fifo_pop),
        .din   (staged),
        .dout  (head),
        .count (fifo_count),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    sgd_seq #(
        .RST_CYCLES (RST_CYCLES)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .reset_req     (reset_req),
        .halt          (halt),
        .head_avail    (!fifo_empty),
        .head_irq_bits (head[CTRL_IDX*WORD_W + DC_CMPL_IRQ +: 10]),
        .head_seq      (head[SEQ_IDX*WORD_W +: 16]),
        .cmd_ready     (cmd_ready),
        .done_pulse    (done_pulse),
        .done_err      (done_err),
        .done_early    (done_early),
        .cmd_valid     (cmd_valid),
        .pop           (fifo_pop),
        .in_reset      (in_reset),
        .active        (active),
        .set_ip        (set_ip),
        .err_hit       (err_hit),
        .early_hit     (early_hit),
        .rd_seq        (rd_seq),
        .wr_seq        (wr_seq)
    );

    assign cmd_desc = head;

    // control register and sticky status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            ip_q     <= 1'b0;
            serr_q   <= 1'b0;
            searly_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q <= {csr_wr_data[5:2], 1'b0, csr_wr_data[0]};
            end
            if (set_ip)                              ip_q <= 1'b1;
            else if (stat_wr && csr_wr_data[SB_IRQ]) ip_q <= 1'b0;
            if (err_hit && ctrl_q[KB_STOP_ERR])           serr_q <= 1'b1;
            else if (stat_wr && csr_wr_data[SB_STOP_ERR]) serr_q <= 1'b0;
            if (early_hit && ctrl_q[KB_STOP_EARLY])         searly_q <= 1'b1;
            else if (stat_wr && csr_wr_data[SB_STOP_EARLY]) searly_q <= 1'b0;
        end
    end

    assign irq    = ip_q && ctrl_q[KB_GIE];
    assign fill16 = 16'(fifo_count);

    always_comb begin
        status_w    = '0;
        status_w[0] = active || !fifo_empty;
        status_w[1] = fifo_empty;
        status_w[2] = fifo_full;
        status_w[3] = 1'b1;
        status_w[4] = 1'b0;
        status_w[5] = halt && !active;
        status_w[6] = in_reset;
        status_w[SB_STOP_ERR]   = serr_q;
        status_w[SB_STOP_EARLY] = searly_q;
        status_w[SB_IRQ]        = ip_q;

        control_w = {26'b0, ctrl_q[5:2], in_reset, ctrl_q[0]};

        unique case (csr_idx)
            3'd0:    csr_rd_data = status_w;
            3'd1:    csr_rd_data = control_w;
            3'd2:    csr_rd_data = {fill16, fill16};
            3'd4:    csr_rd_data = {wr_seq, rd_seq};
            default: csr_rd_data = '0;
        endcase
    end

    // R3: an offer is held steady until the mover takes it
    p_desc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready && !reset_req |=> cmd_valid && $stable(cmd_desc));

    // R7, R9: a halt seen while not offering keeps the offer low
    p_halt_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halt && !cmd_valid |=> !cmd_valid);

    // R10: a reset request empties the FIFO on its own edge
    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> fifo_empty);

    // R6: an interrupt cause always lands in the pending flag
    p_ip_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_ip |=> ip_q);

    // R5: with no cause, a write of zeros leaves pending untouched
    p_w1c_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr && !csr_wr_data[SB_IRQ] && ip_q |=> ip_q);
endmodule

// File: tb/sgdma_dispatcher_test.sv
module sgdma_dispatcher_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int RSTC       = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         desc_wr_en = 1'b0;
    logic [2:0]   desc_wr_idx = '0;
    logic [31:0]  desc_wr_data = '0;
    logic         csr_wr_en = 1'b0;
    logic [2:0]   csr_idx = '0;
    logic [31:0]  csr_wr_data = '0;
    logic [31:0]  csr_rd_data;
    logic         cmd_valid;
    logic         cmd_ready = 1'b0;
    logic [255:0] cmd_desc;
    logic         done_pulse = 1'b0;
    logic [7:0]   done_err = '0;
    logic         done_early = 1'b0;
    logic         irq;

    int checks = 0;
    int errors = 0;
    logic [255:0] sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sgdma_dispatcher #(.FIFO_DEPTH(DEPTH), .RST_CYCLES(RSTC)) uut (
        .clk(clk), .rst_n(rst_n),
        .desc_wr_en(desc_wr_en), .desc_wr_idx(desc_wr_idx), .desc_wr_data(desc_wr_data),
        .csr_wr_en(csr_wr_en), .csr_idx(csr_idx), .csr_wr_data(csr_wr_data),
        .csr_rd_data(csr_rd_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_desc(cmd_desc),
        .done_pulse(done_pulse), .done_err(done_err), .done_early(done_early),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [255:0] mk(input logic [15:0] seq, input logic [31:0] ctl);
        logic [255:0] d;
        for (int i = 0; i < 8; i++) d[32*i +: 32] = $urandom;
        d[96 +: 16]  = seq;
        d[224 +: 32] = ctl | 32'h8000_0000;
        return d;
    endfunction

    function automatic logic exp_ip(input logic [31:0] ctl, input logic [7:0] err, input logic early);
        return ctl[14] || (|(err & ctl[23:16])) || (early && ctl[15]);
    endfunction

    task automatic dwr(input logic [2:0] idx, input logic [31:0] data);
        desc_wr_en = 1'b1; desc_wr_idx = idx; desc_wr_data = data;
        @(posedge clk); @(negedge clk);
        desc_wr_en = 1'b0;
    endtask

    task automatic cwr(input logic [2:0] idx, input logic [31:0] data);
        csr_wr_en = 1'b1; csr_idx = idx; csr_wr_data = data;
        @(posedge clk); @(negedge clk);
        csr_wr_en = 1'b0;
    endtask

    task automatic crd(input logic [2:0] idx, output logic [31:0] v);
        csr_idx = idx;
        #1;
        v = csr_rd_data;
    endtask

    task automatic push(input logic [255:0] d);
        for (int i = 0; i < 8; i++) dwr(3'(i), d[32*i +: 32]);
        if (sb.size() < DEPTH) sb.push_back(d);
    endtask

    task automatic serve(input logic [7:0] err, input logic early, input int hold, input string tag);
        logic [255:0] exp;
        int n;
        n = 0;
        while (!cmd_valid && n < 200) begin @(negedge clk); n++; end
        exp = (sb.size() > 0) ? sb.pop_front() : '0;
        chk({tag, " descriptor"}, cmd_desc, exp);
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk("R3 offer held", {cmd_valid, cmd_desc}, {1'b1, exp});
        end
        cmd_ready = 1'b1; @(negedge clk); cmd_ready = 1'b0;
        chk("R3 no offer while in flight", cmd_valid, 1'b0);
        done_err = err; done_early = early; done_pulse = 1'b1;
        @(negedge clk);
        done_pulse = 1'b0; done_err = '0; done_early = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0]  v;
        logic [255:0] d;
        int n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 reset state
        crd(3'd0, v); chk("R4 status after reset", v, 32'h00A);
        chk("R4 irq and valid after reset", {irq, cmd_valid}, 2'b00);

        // R1 staging only, control word without go
        for (int i = 0; i < 7; i++) dwr(3'(i), $urandom);
        dwr(3'd7, 32'h0000_4000);
        repeat (2) @(negedge clk);
        crd(3'd2, v); chk("R1 no push without go", v, 32'h0);
        chk("R1 no offer without go", cmd_valid, 1'b0);

        // R1 commit with go, R11 fill level
        d = mk(16'h0011, 32'h0);
        push(d);
        @(negedge clk);
        chk("R1 committed descriptor", {cmd_valid, cmd_desc}, {1'b1, d});
        crd(3'd2, v); chk("R11 fill level one", v, 32'h0001_0001);

        // R2 fill up, then a dropped commit
        for (int i = 0; i < 3; i++) push(mk(16'(16'h0020 + i), 32'h0));
        crd(3'd2, v); chk("R11 fill level full", v, 32'h0004_0004);
        crd(3'd0, v); chk("R4 full flag", v[2:0], 3'b101);
        push(mk(16'hBAD0, 32'h0));
        crd(3'd2, v); chk("R2 commit dropped when full", v, 32'h0004_0004);
        serve(8'h0, 1'b0, 2, "R2 order 0");
        crd(3'd4, v); chk("R11 sequence numbers", v, 32'h0011_0011);
        for (int i = 0; i < 3; i++) serve(8'h0, 1'b0, 0, "R2 order");
        repeat (2) @(negedge clk);
        crd(3'd0, v); chk("R4 idle status", v, 32'h00A);
        crd(3'd4, v); chk("R11 last sequence", v, 32'h0022_0022);

        // R3 stray completion ignored
        done_pulse = 1'b1; done_err = 8'hFF; @(negedge clk); done_pulse = 1'b0; done_err = '0;
        crd(3'd0, v); chk("R3 stray completion ignored", v, 32'h00A);

        // R6 completion interrupt, gated by enable
        push(mk(16'h0030, 32'h0000_4000));
        serve(8'h0, 1'b0, 0, "R6 cmpl");
        crd(3'd0, v); chk("R6 pending set", v[9], 1'b1);
        chk("R6 irq gated off", irq, 1'b0);
        cwr(3'd0, 32'h0);
        crd(3'd0, v); chk("R5 write zero keeps pending", v[9], 1'b1);
        cwr(3'd1, 32'h10);
        chk("R6 irq enabled", irq, 1'b1);
        cwr(3'd0, 32'h200);
        crd(3'd0, v); chk("R5 write one clears pending", {v[9], irq}, 2'b00);

        // R6 error mask and early-termination interrupt
        push(mk(16'h0031, 32'h0004_0000));
        serve(8'h04, 1'b0, 0, "R6 mask hit");
        chk("R6 masked error raises irq", irq, 1'b1);
        cwr(3'd0, 32'h200);
        push(mk(16'h0032, 32'h0004_0000));
        serve(8'h02, 1'b0, 0, "R6 mask miss");
        chk("R6 unmasked error no irq", irq, 1'b0);
        push(mk(16'h0033, 32'h0000_8000));
        serve(8'h00, 1'b1, 0, "R6 early");
        chk("R6 early irq", irq, 1'b1);
        cwr(3'd0, 32'h200);

        // R7 stop on error
        cwr(3'd1, 32'h14);
        push(mk(16'h0040, 32'h0));
        push(mk(16'h0041, 32'h0));
        serve(8'h01, 1'b0, 0, "R7 first");
        repeat (5) @(negedge clk);
        chk("R7 halted after error", cmd_valid, 1'b0);
        crd(3'd0, v); chk("R7 stopped bits", {v[7], v[5]}, 2'b11);
        crd(3'd2, v); chk("R7 descriptor kept", v, 32'h0001_0001);
        cwr(3'd0, 32'h80);
        serve(8'h0, 1'b0, 0, "R7 resumed");

        // R8 stop on early termination
        cwr(3'd1, 32'h18);
        push(mk(16'h0050, 32'h0));
        push(mk(16'h0051, 32'h0));
        serve(8'h0, 1'b1, 0, "R8 first");
        repeat (5) @(negedge clk);
        crd(3'd0, v); chk("R8 halted after early", {cmd_valid, v[8], v[5]}, 3'b011);
        cwr(3'd0, 32'h100);
        serve(8'h0, 1'b0, 0, "R8 resumed");

        // R9 stop and stop-fetch
        cwr(3'd1, 32'h01);
        push(mk(16'h0060, 32'h0));
        repeat (4) @(negedge clk);
        crd(3'd0, v); chk("R9 stop holds descriptor", {cmd_valid, v[5]}, 2'b01);
        cwr(3'd1, 32'h00);
        serve(8'h0, 1'b0, 0, "R9 after stop");
        cwr(3'd1, 32'h20);
        push(mk(16'h0061, 32'h0));
        repeat (4) @(negedge clk);
        chk("R9 stop-fetch holds descriptor", cmd_valid, 1'b0);
        cwr(3'd1, 32'h00);
        serve(8'h0, 1'b0, 0, "R9 after stop-fetch");

        // R10 soft reset
        push(mk(16'h0070, 32'h0));
        push(mk(16'h0071, 32'h0));
        dwr(3'd0, 32'hDEAD_BEEF);
        cwr(3'd1, 32'h02);
        sb.delete();
        crd(3'd0, v); chk("R10 resetting and flushed", {v[6], v[0], cmd_valid}, 3'b100);
        crd(3'd2, v); chk("R10 fill cleared", v, 32'h0);
        crd(3'd1, v); chk("R10 reset bit reads one", v[1], 1'b1);
        n = 0;
        crd(3'd0, v);
        while (v[6] && n < 100) begin n++; @(negedge clk); crd(3'd0, v); end
        chk("R10 reset length", 256'(n), 256'(RSTC));
        crd(3'd1, v); chk("R10 reset bit self-clears", v[1], 1'b0);
        dwr(3'd7, 32'h8000_0000);
        sb.push_back({32'h8000_0000, 224'b0});
        serve(8'h0, 1'b0, 0, "R10 staging cleared");

        // random traffic, R1 R2 R3 R6 R11
        cwr(3'd1, 32'h10);
        for (int it = 0; it < 40; it++) begin
            logic [7:0]  e;
            logic        ea;
            logic [31:0] ctl;
            int np;
            np = 1 + int'($urandom % 2);
            for (int p = 0; p < np; p++) begin
                if (sb.size() < DEPTH) push(mk(16'($urandom), $urandom & 32'h01FF_FFFF));
            end
            ctl = sb[0][224 +: 32];
            d   = sb[0];
            e   = ($urandom % 4 == 0) ? 8'($urandom) : 8'h0;
            ea  = ($urandom % 4 == 0);
            serve(e, ea, int'($urandom % 3), "R2 random");
            chk("R6 random irq", irq, exp_ip(ctl, e, ea));
            crd(3'd4, v); chk("R11 random sequence", v, {d[96 +: 16], d[96 +: 16]});
            if (irq) cwr(3'd0, 32'h200);
        end
        while (sb.size() > 0) serve(8'h0, 1'b0, 0, "R2 drain");
        repeat (3) @(negedge clk);
        crd(3'd0, v); chk("R4 final status", v[2:0], 3'b010);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule